// File: doc/BRIEF.md
# Four-Way Set-Associative Tag Directory

This block keeps the tags and the coherence state for a 32-Kbyte cache of 32-byte lines, arranged as 256 sets of four ways. A 32-bit physical address splits into a 19-bit tag, an 8-bit set index and a 5-bit byte offset. The index MSB splits the sets into two halves. Lines from even 4-Kbyte pages go to the lower 128 sets and lines from odd pages go to the upper 128. The data array is not part of this block.

The block has one tag port, shared by lookups, fills and single-line invalidates. Each operation completes in one cycle, and its result is registered for the next cycle. Fills allocate into the lowest invalid way. When the set has no invalid way, the fill replaces the way that a 3-bit tree pseudo-LRU selects. Three controls act separately:

- **Disable** makes every lookup miss and stops allocation.
- **Lock** stops allocation but still serves hits.
- **Flash invalidate** walks every set, one per cycle, and holds busy high while it runs.

A separate combinational path tells the core whether a touch or prefetch hint must be dropped.

Top module: `tagdir_top`

## Requirements
- R1: The set index is address bits [12:5] and the tag is bits [31:13]. Bits [4:0] do not affect matching. Bit 12 is the index MSB: 0 selects sets 0–127 and 1 selects sets 128–255, so two addresses that differ only in bit 12 occupy different sets.
- R2: A lookup that is accepted in one cycle raises `lk_valid_o` in the next cycle, together with hit, way and state. States are encoded as invalid=0, shared=1, exclusive=2, modified=3. A miss reports way 0 and state 0.
- R3: An accepted fill raises `fill_ack_o` in the next cycle, with the way it used. If the tag is already present, that way is rewritten. Otherwise the fill uses the lowest-numbered invalid way.
- R4: When all four ways are valid, the victim comes from three bits p0, p1 and p2. If p0=0, the victim is way 0 when p1=0 and way 1 when p1=1. If p0=1, the victim is way 2 when p2=0 and way 3 when p2=1.
- R5: A lookup hit and a fill each mark their way as most recent: p0 is set to 1 for ways 0 and 1 and to 0 for ways 2 and 3, and the pair bit is set to point at the other way of the pair. Misses and invalidates leave the bits unchanged. Reset and flash clear the bits to 0.
- R6: An invalidate by address clears only the matching line, and it takes effect even while lock or disable is set.
- R7: While disable is set, every lookup reports a miss and fills are dropped with no ack. Stored lines survive and hit again once disable is cleared.
- R8: While lock is set, fills are dropped with no ack, and lookups still hit.
- R9: A flash request made while idle raises `busy_o` from the next cycle for exactly 256 cycles, and all lines are invalid afterwards. A flash request made while busy is ignored.
- R10: While `busy_o` is high, lookup, fill and invalidate requests are ignored.
- R11: `hint_drop_o` equals `hint_i` AND (translation miss OR direct-store OR cache-inhibited OR lock), with no delay.
- R12: When requests arrive in the same cycle, invalidate takes priority over fill, and fill over lookup. A request that loses produces no ack or valid.
- R13: After reset, every line is invalid and `busy_o`, `lk_valid_o` and `fill_ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_disable_i | input | 1 | Force misses and block allocation |
| cfg_lock_i | input | 1 | Block allocation; hits still served |
| flash_inv_i | input | 1 | Start invalidating every line |
| busy_o | output | 1 | Flash walk in progress |
| lookup_req_i | input | 1 | Lookup request |
| lookup_addr_i | input | 32 | Lookup address |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_way_o | output | 2 | Way that hit |
| lk_state_o | output | 2 | State of the line that hit |
| fill_i | input | 1 | Fill (allocate) request |
| fill_addr_i | input | 32 | Fill address |
| fill_state_i | input | 2 | State written by the fill |
| fill_ack_o | output | 1 | Fill was performed |
| fill_way_o | output | 2 | Way that was written |
| inv_i | input | 1 | Invalidate one line by address |
| inv_addr_i | input | 32 | Invalidate address |
| hint_i | input | 1 | Touch or prefetch hint presented |
| hint_xlate_miss_i | input | 1 | Hint address missed translation |
| hint_dstore_i | input | 1 | Hint targets a direct-store segment |
| hint_inhibit_i | input | 1 | Hint targets a cache-inhibited page |
| hint_drop_o | output | 1 | Hint must be treated as a no-op |

## Verification
The assertions assume that the control inputs are stable around the clock edge. They also assume that a fill never writes the invalid state, because a hit is expected to report a non-zero state. The stimulus therefore draws fill states only from shared, exclusive and modified. Requests are driven at the falling edge, and lock and disable change only between operations. Tags and indices are drawn from small pools, so that sets fill up and force replacement, and the bit-12 even/odd split gets exercised.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  localparam int unsigned WAYS   = 4;
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned PLRU_W = WAYS - 1;
  localparam int unsigned ST_W   = 2;

  typedef enum logic [ST_W-1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_MOD = 2'd3
  } line_st_e;

  // mark way as most recent: top bit points away from its half, pair bit at its sibling
  function automatic logic [PLRU_W-1:0] plru_touch(logic [PLRU_W-1:0] cur, logic [WAY_W-1:0] way);
    logic [PLRU_W-1:0] nxt;
    nxt    = cur;
    nxt[0] = ~way[1];
    if (!way[1]) nxt[1] = ~way[0];
    else         nxt[2] = ~way[0];
    return nxt;
  endfunction
endpackage

// File: rtl/tagdir_match.sv
module tagdir_match
  import tagdir_pkg::*;
#(
  parameter int unsigned TAG_W = 19
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0][ST_W-1:0]  st_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            valid_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o,
  output logic [ST_W-1:0]            st_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign valid_o[w] = (st_i[w] != ST_INV);
    assign match[w]   = valid_o[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o = |match;
    way_o = '0;
    st_o  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        way_o = WAY_W'(w);
        st_o  = st_i[w];
      end
    end
  end
endmodule

// File: rtl/tagdir_victim.sv
module tagdir_victim
  import tagdir_pkg::*;
(
  input  logic [WAYS-1:0]   valid_i,
  input  logic [PLRU_W-1:0] plru_i,
  output logic [WAY_W-1:0]  way_o
);
  always_comb begin
    way_o = plru_i[0] ? {1'b1, plru_i[2]} : {1'b0, plru_i[1]};
    // invalid ways take precedence, lowest first
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tagdir_sweep.sv
module tagdir_sweep #(
  parameter int unsigned SETS = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic                    busy_o,
  output logic [$clog2(SETS)-1:0] idx_o
);
  localparam int unsigned IDX_W = $clog2(SETS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (idx_o == IDX_W'(SETS - 1)) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end else if (start_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end
  end
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned SETS       = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_disable_i,
  input  logic              cfg_lock_i,
  input  logic              flash_inv_i,
  output logic              busy_o,
  input  logic              lookup_req_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic [1:0]        lk_way_o,
  output logic [1:0]        lk_state_o,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [1:0]        fill_state_i,
  output logic              fill_ack_o,
  output logic [1:0]        fill_way_o,
  input  logic              inv_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  input  logic              hint_i,
  input  logic              hint_xlate_miss_i,
  input  logic              hint_dstore_i,
  input  logic              hint_inhibit_i,
  output logic              hint_drop_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [WAYS-1:0][ST_W-1:0]  st_q   [SETS];
  logic [PLRU_W-1:0]          plru_q [SETS];

  logic [IDX_W-1:0]  sweep_idx;
  logic              inv_go, fill_go, lk_go;
  logic [ADDR_W-1:0] op_addr;
  logic [IDX_W-1:0]  op_idx;
  logic [TAG_W-1:0]  op_tag;
  logic [WAYS-1:0]   set_valid;
  logic              m_hit;
  logic [WAY_W-1:0]  m_way, vict_way, fill_way;
  logic [ST_W-1:0]   m_st;
  logic              lk_hit;
  logic              unused_off;

  tagdir_sweep #(.SETS(SETS)) i_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(flash_inv_i),
    .busy_o (busy_o),
    .idx_o  (sweep_idx)
  );

  // single tag port: invalidate > fill > lookup
  assign inv_go  = inv_i && !busy_o;
  assign fill_go = fill_i && !inv_i && !busy_o && !cfg_disable_i && !cfg_lock_i;
  assign lk_go   = lookup_req_i && !inv_i && !fill_i && !busy_o;

  assign op_addr = inv_i ? inv_addr_i : (fill_i ? fill_addr_i : lookup_addr_i);
  assign op_idx  = op_addr[OFF_W +: IDX_W];
  assign op_tag  = op_addr[ADDR_W-1 -: TAG_W];

  assign unused_off = ^{lookup_addr_i[OFF_W-1:0], fill_addr_i[OFF_W-1:0], inv_addr_i[OFF_W-1:0]};

  tagdir_match #(.TAG_W(TAG_W)) i_match (
    .tags_i (tag_q[op_idx]),
    .st_i   (st_q[op_idx]),
    .tag_i  (op_tag),
    .valid_o(set_valid),
    .hit_o  (m_hit),
    .way_o  (m_way),
    .st_o   (m_st)
  );

  tagdir_victim i_victim (
    .valid_i(set_valid),
    .plru_i (plru_q[op_idx]),
    .way_o  (vict_way)
  );

  assign fill_way = m_hit ? m_way : vict_way;
  assign lk_hit   = m_hit && !cfg_disable_i;

  always_ff @(posedge clk_i) begin
    if (fill_go) tag_q[op_idx][fill_way] <= op_tag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        st_q[s]   <= '0;
        plru_q[s] <= '0;
      end
    end else if (busy_o) begin
      st_q[sweep_idx]   <= '0;
      plru_q[sweep_idx] <= '0;
    end else if (inv_go) begin
      if (m_hit) st_q[op_idx][m_way] <= ST_INV;
    end else if (fill_go) begin
      st_q[op_idx][fill_way] <= fill_state_i;
      plru_q[op_idx]         <= plru_touch(plru_q[op_idx], fill_way);
    end else if (lk_go && lk_hit) begin
      plru_q[op_idx] <= plru_touch(plru_q[op_idx], m_way);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_way_o   <= '0;
      lk_state_o <= '0;
      fill_ack_o <= 1'b0;
      fill_way_o <= '0;
    end else begin
      lk_valid_o <= lk_go;
      lk_hit_o   <= lk_go && lk_hit;
      lk_way_o   <= (lk_go && lk_hit) ? m_way : '0;
      lk_state_o <= (lk_go && lk_hit) ? m_st : '0;
      fill_ack_o <= fill_go;
      fill_way_o <= fill_go ? fill_way : '0;
    end
  end

  assign hint_drop_o = hint_i && (hint_xlate_miss_i || hint_dstore_i || hint_inhibit_i || cfg_lock_i);
endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker #(
  parameter int unsigned SETS = 256
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_disable_i,
  input logic       cfg_lock_i,
  input logic       flash_inv_i,
  input logic       busy_o,
  input logic       lookup_req_i,
  input logic       lk_valid_o,
  input logic       lk_hit_o,
  input logic [1:0] lk_state_o,
  input logic       fill_i,
  input logic       fill_ack_o,
  input logic       inv_i,
  input logic       hint_i,
  input logic       hint_drop_o
);
  localparam int unsigned CNT_W = $clog2(SETS) + 1;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  p_lookup_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_req_i && !inv_i && !fill_i && !busy_o |=> lk_valid_o);
  p_miss_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_o && !lk_hit_o |-> lk_state_o == 2'd0);
  p_hit_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_valid_o && lk_state_o != 2'd0);
  p_disable_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_disable_i |=> !lk_hit_o && !fill_ack_o);
  p_lock_no_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_lock_i |=> !fill_ack_o);
  p_flash_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_inv_i && !busy_o |=> busy_o);
  p_flash_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt == CNT_W'(SETS));
  p_busy_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !lk_valid_o && !fill_ack_o);
  p_hint_lock_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_i && cfg_lock_i |-> hint_drop_o);
  p_hint_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hint_i |-> !hint_drop_o);
  p_inv_priority_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i && !busy_o |=> !lk_valid_o && !fill_ack_o);
endmodule

bind tagdir_top tagdir_checker #(.SETS(SETS)) i_chk (.*);

// File: tb/test_tagdir_top.sv
module test_tagdir_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_disable_i = 1'b0, cfg_lock_i = 1'b0, flash_inv_i = 1'b0;
  logic        busy_o;
  logic        lookup_req_i = 1'b0;
  logic [31:0] lookup_addr_i = '0;
  logic        lk_valid_o, lk_hit_o;
  logic [1:0]  lk_way_o, lk_state_o;
  logic        fill_i = 1'b0;
  logic [31:0] fill_addr_i = '0;
  logic [1:0]  fill_state_i = '0;
  logic        fill_ack_o;
  logic [1:0]  fill_way_o;
  logic        inv_i = 1'b0;
  logic [31:0] inv_addr_i = '0;
  logic        hint_i = 1'b0, hint_xlate_miss_i = 1'b0, hint_dstore_i = 1'b0, hint_inhibit_i = 1'b0;
  logic        hint_drop_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [18:0] m_tag  [256][4];
  logic [1:0]  m_st   [256][4];
  logic [2:0]  m_plru [256];

  always #(CLK_P/2) clk_i = ~clk_i;

  tagdir_top i_tagdir_top (.*);

  function automatic logic [31:0] mk(logic [18:0] t, logic [7:0] s, logic [4:0] o);
    return {t, s, o};
  endfunction

  function automatic int m_find(logic [31:0] a);
    for (int w = 0; w < 4; w++)
      if (m_st[a[12:5]][w] != 2'd0 && m_tag[a[12:5]][w] == a[31:13]) return w;
    return -1;
  endfunction

  function automatic int m_victim(logic [7:0] s);
    for (int w = 0; w < 4; w++) if (m_st[s][w] == 2'd0) return w;
    if (m_plru[s][0] == 1'b0) return m_plru[s][1] ? 1 : 0;
    return m_plru[s][2] ? 3 : 2;
  endfunction

  function automatic logic [2:0] m_touch(logic [2:0] p, int w);
    logic [2:0] r;
    r = p;
    r[0] = (w < 2);
    if (w == 0) r[1] = 1'b1;
    if (w == 1) r[1] = 1'b0;
    if (w == 2) r[2] = 1'b1;
    if (w == 3) r[2] = 1'b0;
    return r;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < 256; s++) begin
      m_plru[s] = '0;
      for (int w = 0; w < 4; w++) m_st[s][w] = '0;
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_lookup(logic [31:0] a, string req);
    int w;
    bit eh;
    @(negedge clk_i);
    lookup_req_i = 1'b1; lookup_addr_i = a;
    @(negedge clk_i);
    lookup_req_i = 1'b0;
    w  = m_find(a);
    eh = (w >= 0) && !cfg_disable_i;
    chk(lk_valid_o == 1'b1, req, int'(lk_valid_o), 1);
    chk(lk_hit_o == eh, req, int'(lk_hit_o), int'(eh));
    chk(lk_way_o == (eh ? 2'(w) : 2'd0), req, int'(lk_way_o), eh ? w : 0);
    chk(lk_state_o == (eh ? m_st[a[12:5]][w] : 2'd0), req, int'(lk_state_o), eh ? int'(m_st[a[12:5]][w]) : 0);
    if (eh) m_plru[a[12:5]] = m_touch(m_plru[a[12:5]], w);
  endtask

  task automatic do_fill(logic [31:0] a, logic [1:0] st, string req);
    int w;
    bit ea;
    @(negedge clk_i);
    fill_i = 1'b1; fill_addr_i = a; fill_state_i = st;
    @(negedge clk_i);
    fill_i = 1'b0;
    ea = !cfg_disable_i && !cfg_lock_i;
    w  = m_find(a);
    if (w < 0) w = m_victim(a[12:5]);
    chk(fill_ack_o == ea, req, int'(fill_ack_o), int'(ea));
    if (ea) begin
      chk(fill_way_o == 2'(w), req, int'(fill_way_o), w);
      m_tag[a[12:5]][w] = a[31:13];
      m_st[a[12:5]][w]  = st;
      m_plru[a[12:5]]   = m_touch(m_plru[a[12:5]], w);
    end
  endtask

  task automatic do_inv(logic [31:0] a);
    int w;
    @(negedge clk_i);
    inv_i = 1'b1; inv_addr_i = a;
    @(negedge clk_i);
    inv_i = 1'b0;
    chk(lk_valid_o == 1'b0 && fill_ack_o == 1'b0, "R6", int'(lk_valid_o), 0);
    w = m_find(a);
    if (w >= 0) m_st[a[12:5]][w] = 2'd0;
  endtask

  // R9 R10: walk length, ignored requests while busy
  task automatic do_flash();
    int n;
    @(negedge clk_i);
    flash_inv_i = 1'b1;
    @(negedge clk_i);
    flash_inv_i = 1'b0;
    n = 0;
    while (busy_o && n < 400) begin
      n++;
      if (n == 10) begin lookup_req_i = 1'b1; fill_i = 1'b0; end
      if (n == 11) begin
        lookup_req_i = 1'b0;
        chk(lk_valid_o == 1'b0, "R10 lookup while busy", int'(lk_valid_o), 0);
        fill_i = 1'b1; fill_addr_i = mk(19'h1, 8'd0, 5'd0); fill_state_i = 2'd1;
      end
      if (n == 12) begin
        fill_i = 1'b0;
        chk(fill_ack_o == 1'b0, "R10 fill while busy", int'(fill_ack_o), 0);
      end
      if (n == 20) flash_inv_i = 1'b1;
      if (n == 21) flash_inv_i = 1'b0;
      @(negedge clk_i);
    end
    chk(n == 256, "R9 busy length", n, 256);
    m_clear();
  endtask

  task automatic hint_check(logic h, logic x, logic d, logic c, string req);
    bit e;
    hint_i = h; hint_xlate_miss_i = x; hint_dstore_i = d; hint_inhibit_i = c;
    #1;
    e = h && (x || d || c || cfg_lock_i);
    chk(hint_drop_o == e, req, int'(hint_drop_o), int'(e));
    hint_i = 1'b0; hint_xlate_miss_i = 1'b0; hint_dstore_i = 1'b0; hint_inhibit_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [18:0] tpool [6];
    logic [7:0]  spool [4];
    void'($urandom(32'h5eed_0042));
    m_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R13
    chk(busy_o == 1'b0 && lk_valid_o == 1'b0 && fill_ack_o == 1'b0, "R13 reset outputs", int'(busy_o), 0);
    do_lookup(mk(19'h12345, 8'd7, 5'd0), "R13 empty after reset");

    // R1 R3: even/odd page split and offset independence
    a = mk(19'h0abcd, 8'h05, 5'd0);
    b = a | 32'h0000_1000;
    do_fill(a, 2'd2, "R3 first fill");
    do_fill(b, 2'd3, "R1 odd half fill");
    chk(fill_way_o == 2'd0, "R1 distinct set way0", int'(fill_way_o), 0);
    do_lookup(a + 32'h1f, "R1 offset ignored");
    do_lookup(b, "R1 odd half hit");
    do_lookup(a ^ 32'h0000_2000, "R1 tag bit differs miss");
    do_fill(a, 2'd1, "R3 refill same tag");
    chk(fill_way_o == 2'd0, "R3 in-place way", int'(fill_way_o), 0);

    // R4 R5: fill set 0x40 fully, then replacement
    for (int i = 0; i < 4; i++) do_fill(mk(19'(i + 16), 8'h40, 5'd0), 2'd1, "R3 lowest invalid");
    do_fill(mk(19'd30, 8'h40, 5'd0), 2'd2, "R4 victim after 4 fills");
    chk(fill_way_o == 2'd0, "R4 victim literal", int'(fill_way_o), 0);
    do_lookup(mk(19'd17, 8'h40, 5'd0), "R5 hit touches");
    do_lookup(mk(19'd99, 8'h40, 5'd0), "R5 miss no touch");
    do_fill(mk(19'd31, 8'h40, 5'd0), 2'd2, "R4 victim after touch");
    chk(fill_way_o == 2'd2, "R4 victim literal 2", int'(fill_way_o), 2);

    // R6: single-line invalidate, under lock
    cfg_lock_i = 1'b1;
    do_inv(mk(19'd30, 8'h40, 5'd0));
    do_lookup(mk(19'd30, 8'h40, 5'd0), "R6 line gone");
    do_lookup(mk(19'd17, 8'h40, 5'd0), "R6 neighbour kept R8 hit under lock");
    // R8
    do_fill(mk(19'd50, 8'h41, 5'd0), 2'd1, "R8 fill dropped when locked");
    do_lookup(mk(19'd50, 8'h41, 5'd0), "R8 no allocation");
    hint_check(1'b1, 1'b0, 1'b0, 1'b0, "R11 lock drops hint");
    cfg_lock_i = 1'b0;

    // R7
    cfg_disable_i = 1'b1;
    do_lookup(a, "R7 disabled miss");
    do_fill(mk(19'd60, 8'h42, 5'd0), 2'd1, "R7 fill dropped");
    cfg_disable_i = 1'b0;
    do_lookup(a, "R7 content survives");
    do_lookup(mk(19'd60, 8'h42, 5'd0), "R7 no allocation");

    // R11
    hint_check(1'b1, 1'b0, 1'b0, 1'b0, "R11 plain hint kept");
    hint_check(1'b1, 1'b1, 1'b0, 1'b0, "R11 xlate miss");
    hint_check(1'b1, 1'b0, 1'b1, 1'b0, "R11 direct store");
    hint_check(1'b1, 1'b0, 1'b0, 1'b1, "R11 inhibited");
    hint_check(1'b0, 1'b1, 1'b1, 1'b1, "R11 no hint");

    // R12: all three at once on a present line
    @(negedge clk_i);
    inv_i = 1'b1; inv_addr_i = b;
    fill_i = 1'b1; fill_addr_i = mk(19'd70, 8'h43, 5'd0); fill_state_i = 2'd1;
    lookup_req_i = 1'b1; lookup_addr_i = a;
    @(negedge clk_i);
    inv_i = 1'b0; fill_i = 1'b0; lookup_req_i = 1'b0;
    chk(fill_ack_o == 1'b0, "R12 fill loses", int'(fill_ack_o), 0);
    chk(lk_valid_o == 1'b0, "R12 lookup loses", int'(lk_valid_o), 0);
    m_st[b[12:5]][m_find(b)] = 2'd0;
    do_lookup(b, "R12 invalidate won");
    do_lookup(mk(19'd70, 8'h43, 5'd0), "R12 fill not done");

    // R9
    do_flash();
    do_lookup(a, "R9 cleared");
    do_lookup(mk(19'd17, 8'h40, 5'd0), "R9 cleared set");
    for (int i = 0; i < 4; i++) do_fill(mk(19'(i + 200), 8'h40, 5'd0), 2'd3, "R9 plru reset fill");
    do_fill(mk(19'd210, 8'h40, 5'd0), 2'd1, "R5 plru after flash");

    // random phase
    for (int i = 0; i < 6; i++) tpool[i] = 19'($urandom);
    spool[0] = 8'h03; spool[1] = 8'h83; spool[2] = 8'hc8; spool[3] = 8'h48;
    for (int i = 0; i < 2500; i++) begin
      int op;
      a  = mk(tpool[$urandom % 6], spool[$urandom % 4], 5'($urandom));
      op = int'($urandom % 100);
      if (op < 4) begin
        cfg_lock_i = ($urandom % 4) == 0;
        cfg_disable_i = ($urandom % 6) == 0;
      end
      if (op < 40)      do_lookup(a, "R2 random lookup");
      else if (op < 75) do_fill(a, 2'(1 + ($urandom % 3)), "R4 random fill");
      else if (op < 90) do_inv(a);
      else              hint_check(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), "R11 random hint");
      if (i == 1250) begin
        cfg_lock_i = 1'b0; cfg_disable_i = 1'b0;
        do_flash();
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule